// File: doc/BRIEF.md
# Hot-Module Quota Regulator

This block sits in front of a shared destination module that many sources target at once. Arbitration inside each router only sees local state, so a source many hops away loses more contests than a neighbour does. This block gives the whole module bandwidth out from one place instead. A source asks for a quota of flits with a request message. The regulator answers with a grant message that names the source and the number of flits it may send. Both message types travel at the top service level. The regulator keeps one budget of flits in flight. The module reports flits as it consumes them, and each report returns that amount to the budget.

Pending requests are held one per source. The highest priority level is served first, and sources inside a level take turns round-robin. When the budget cannot cover a whole request, the regulator grants what is left and keeps the remainder queued. A request is never dropped. Before traffic starts, configuration writes preload a per-source credit. The credit is reserved from the budget and sent as a grant flagged as a preload, so a lightly loaded source can send without waiting a request round trip.

Top module: `hm_quota_regulator`

## Requirements
- R1: After reset the grant channel is idle and the full budget (CAP flits, default 32) is free.
- R2: A request is taken only when its service-level field equals the top level (all ones, 3 with the default 2-bit field); requests at any other level are ignored.
- R3: The quota a request asks for is the smaller of its amount and its queue-size field; a request asking for zero is ignored.
- R4: A pending request is granted two clock edges after it is presented, if the budget allows: `gnt_valid` pulses for one cycle, `gnt_lvl` carries the top level, `gnt_pre` is 0, and `gnt_amt` is the smaller of the pending quota and the free budget, never zero.
- R5: The flits granted or preloaded and not yet consumed never exceed CAP; while nothing is free, no grant is issued.
- R6: The part of a request that the budget could not cover stays pending and is granted once consumption frees capacity.
- R7: Among pending requests, one with a larger priority field (1 above 0 with the default 1-bit field) is granted first.
- R8: Within one priority level, grants rotate round-robin: the search starts at the source after the last one granted at that level, wrapping from the highest source index to 0; after reset the search starts at source 0.
- R9: A new request from a source that already has one pending replaces the pending quota and priority.
- R10: A configuration write whose credit is non-zero and fits the free budget reserves that credit and, one edge later, emits a grant to that source with `gnt_pre` = 1; a request grant due in that same cycle is delayed by one cycle.
- R11: A configuration write whose credit is zero or larger than the free budget has no effect: no grant and no reservation.
- R12: A consumption report returns its amount to the budget; reports beyond what is outstanding leave the whole budget free, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request message present |
| req_src | input | SW | Requesting source index |
| req_lvl | input | LVW | Service level the request travelled at |
| req_pri | input | PW | Request priority, larger is more urgent |
| req_amt | input | QW | Flits asked for |
| req_qsize | input | QW | Source queue occupancy |
| cfg_we | input | 1 | Preload-credit write |
| cfg_src | input | SW | Source receiving the preload |
| cfg_credit | input | QW | Preload credit in flits |
| cons_valid | input | 1 | Module consumption report |
| cons_amt | input | QW | Flits consumed |
| gnt_valid | output | 1 | Grant message present |
| gnt_src | output | SW | Source the grant is for |
| gnt_amt | output | QW | Flits granted |
| gnt_pre | output | 1 | Grant comes from a preload write |
| gnt_lvl | output | LVW | Service level the grant is sent at |

## Verification
The bench aims at the budget edges. It exhausts the budget and then frees it a few flits at a time. A design that over-granted or dropped the remainder would produce an extra or a missing grant of the wrong size. It sends an over-sized consumption report on an empty budget and then preloads a full CAP. A counter that wrapped would refuse that credit. It queues mixed-priority and same-priority requests together, so a design that ignored priority or moved its round-robin pointer wrongly would return grants in the wrong order. It puts a preload in the same cycle as a due grant, replaces a pending request, and sends off-level, zero-quota and oversize-preload stimulus. A design that mishandled any of these would emit a grant the scoreboard did not expect.

// File: rtl/qr_pkg.sv
// Shared definitions for the hot-module quota regulator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package qr_pkg;

    // Default sizing, shared by the top and its sub-blocks.
    localparam int DEF_NSRC = 4;
    localparam int DEF_NPRI = 2;
    localparam int DEF_QW   = 8;
    localparam int DEF_CAP  = 32;
    localparam int DEF_LVW  = 2;

    // What happens to one pending-request slot on the next edge.
    typedef enum logic [1:0] {
        SLOT_KEEP,
        SLOT_LOAD,
        SLOT_TAKE
    } slot_op_e;

endpackage

// File: rtl/qr_rr_arb.sv
// Round-robin picker over N request lines.
// Remembers the last winner and searches from the next index, wrapping.
// Assumes: adv is asserted only in a cycle where win_vld is high and the
// winner is really served.
module qr_rr_arb #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic          win_vld,
    output logic [IW-1:0] win_idx
);

    logic [IW-1:0] last_q;

    // Search the request lines starting one past the last winner.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = int'(last_q) + k;
            if (c >= N) c = c - N;
            if (!win_vld && req[c]) begin
                win_vld = 1'b1;
                win_idx = IW'(c);
            end
        end
    end

    // Record the served winner so the next search starts after it.
    always_ff @(posedge clk) begin
        if (!rst_n)   last_q <= IW'(N - 1);
        else if (adv) last_q <= win_idx;
    end

endmodule

// File: rtl/qr_pend_table.sv
// One pending-request slot per source: valid flag, quota left, priority.
// A load replaces a slot; a take lowers the quota and frees the slot once
// the quota is used up. A load wins over a take to the same slot.
// Assumes: tk_amt never exceeds the quota of the slot it names.
module qr_pend_table
    import qr_pkg::*;
#(
    parameter int NSRC = DEF_NSRC,
    parameter int NPRI = DEF_NPRI,
    parameter int QW   = DEF_QW,
    localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int PW  = (NPRI > 1) ? $clog2(NPRI) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic [SW-1:0]             ld_src,
    input  logic [QW-1:0]             ld_amt,
    input  logic [PW-1:0]             ld_pri,
    input  logic                      tk_en,
    input  logic [SW-1:0]             tk_src,
    input  logic [QW-1:0]             tk_amt,
    output logic [NSRC-1:0]           slot_vld,
    output logic [NSRC-1:0][QW-1:0]   slot_amt,
    output logic [NSRC-1:0][PW-1:0]   slot_pri
);

    for (genvar s = 0; s < NSRC; s++) begin : g_slot
        slot_op_e op;

        // Decide this slot's update for the coming edge.
        always_comb begin
            if (ld_en && ld_src == SW'(s))      op = SLOT_LOAD;
            else if (tk_en && tk_src == SW'(s)) op = SLOT_TAKE;
            else                                op = SLOT_KEEP;
        end

        // Apply the update to the slot registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[s] <= 1'b0;
                slot_amt[s] <= '0;
                slot_pri[s] <= '0;
            end else begin
                case (op)
                    SLOT_LOAD: begin
                        slot_vld[s] <= 1'b1;
                        slot_amt[s] <= ld_amt;
                        slot_pri[s] <= ld_pri;
                    end
                    SLOT_TAKE: begin
                        if (tk_amt >= slot_amt[s]) begin
                            slot_vld[s] <= 1'b0;
                            slot_amt[s] <= '0;
                        end else begin
                            slot_amt[s] <= slot_amt[s] - tk_amt;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/qr_budget.sv
// Counts flits granted or preloaded and not yet consumed, and reports the
// free part of the budget. Consumption beyond the count saturates at zero.
// Assumes: add_amt never exceeds the free budget reported the same cycle.
module qr_budget
    import qr_pkg::*;
#(
    parameter int CAP = DEF_CAP,
    parameter int QW  = DEF_QW,
    localparam int BW = $clog2(CAP + 1),
    localparam int WW = ((QW > BW) ? QW : BW) + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [QW-1:0] add_amt,
    input  logic          sub_en,
    input  logic [QW-1:0] sub_amt,
    output logic [BW-1:0] free
);

    logic [BW-1:0] out_q;
    logic [WW-1:0] sum_x;
    logic [WW-1:0] sub_x;
    logic [WW-1:0] nxt_x;

    // Next outstanding count: add the new reservation, remove consumption.
    always_comb begin
        sum_x = WW'(out_q) + (add_en ? WW'(add_amt) : '0);
        sub_x = sub_en ? WW'(sub_amt) : '0;
        nxt_x = (sub_x >= sum_x) ? '0 : (sum_x - sub_x);
    end

    // Hold the outstanding count.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= BW'(nxt_x);
    end

    assign free = BW'(CAP) - out_q;

endmodule

// File: rtl/hm_quota_regulator.sv
// Quota regulator for a heavily shared destination module.
// Accepts top-level request messages into a per-source pending table.
// Serves the highest priority level first, round-robin inside a level, and
// never grants past the free budget. Configuration writes reserve a preload
// credit and emit it as a flagged grant, taking the grant slot that cycle.
// Assumes: the module's consumption reports only cover flits it was granted,
// and CAP fits in QW bits.
module hm_quota_regulator
    import qr_pkg::*;
#(
    parameter int NSRC = DEF_NSRC,
    parameter int NPRI = DEF_NPRI,
    parameter int QW   = DEF_QW,
    parameter int CAP  = DEF_CAP,
    parameter int LVW  = DEF_LVW,
    localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int PW  = (NPRI > 1) ? $clog2(NPRI) : 1,
    localparam int BW  = $clog2(CAP + 1),
    localparam int WW  = ((QW > BW) ? QW : BW) + 1,
    localparam int TOP_LVL = (1 << LVW) - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [SW-1:0]  req_src,
    input  logic [LVW-1:0] req_lvl,
    input  logic [PW-1:0]  req_pri,
    input  logic [QW-1:0]  req_amt,
    input  logic [QW-1:0]  req_qsize,
    input  logic           cfg_we,
    input  logic [SW-1:0]  cfg_src,
    input  logic [QW-1:0]  cfg_credit,
    input  logic           cons_valid,
    input  logic [QW-1:0]  cons_amt,
    output logic           gnt_valid,
    output logic [SW-1:0]  gnt_src,
    output logic [QW-1:0]  gnt_amt,
    output logic           gnt_pre,
    output logic [LVW-1:0] gnt_lvl
);

    logic [QW-1:0]             ask;
    logic                      req_take;
    logic                      cfg_take;
    logic [BW-1:0]             free_w;
    logic [NSRC-1:0]           slot_vld;
    logic [NSRC-1:0][QW-1:0]   slot_amt;
    logic [NSRC-1:0][PW-1:0]   slot_pri;
    logic [NPRI-1:0]           lvl_vld;
    logic [NPRI-1:0][SW-1:0]   lvl_idx;
    logic                      any_vld;
    logic [PW-1:0]             sel_lvl;
    logic [SW-1:0]             sel_src;
    logic                      give;
    logic [WW-1:0]             pick_x;
    logic [WW-1:0]             free_x;
    logic [QW-1:0]             gamt;
    logic                      add_en;
    logic [QW-1:0]             add_amt;

    // Effective quota asked: never more than the source's own backlog.
    assign ask      = (req_amt < req_qsize) ? req_amt : req_qsize;
    assign req_take = req_valid && (req_lvl == LVW'(TOP_LVL)) && (ask != '0);

    // A preload is taken only when it is non-zero and fits the free budget.
    assign free_x   = WW'(free_w);
    assign cfg_take = cfg_we && (cfg_credit != '0) && (WW'(cfg_credit) <= free_x);

    qr_pend_table #(.NSRC(NSRC), .NPRI(NPRI), .QW(QW)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (req_take),
        .ld_src   (req_src),
        .ld_amt   (ask),
        .ld_pri   (req_pri),
        .tk_en    (give),
        .tk_src   (sel_src),
        .tk_amt   (gamt),
        .slot_vld (slot_vld),
        .slot_amt (slot_amt),
        .slot_pri (slot_pri)
    );

    // One round-robin picker per priority level.
    for (genvar l = 0; l < NPRI; l++) begin : g_lvl
        logic [NSRC-1:0] mask;

        // Slots pending at this priority level.
        always_comb begin
            for (int s = 0; s < NSRC; s++)
                mask[s] = slot_vld[s] && (slot_pri[s] == PW'(l));
        end

        qr_rr_arb #(.N(NSRC)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (mask),
            .adv     (give && (sel_lvl == PW'(l))),
            .win_vld (lvl_vld[l]),
            .win_idx (lvl_idx[l])
        );
    end

    // Highest non-empty priority level wins.
    always_comb begin
        any_vld = 1'b0;
        sel_lvl = '0;
        sel_src = '0;
        for (int l = 0; l < NPRI; l++) begin
            if (lvl_vld[l]) begin
                any_vld = 1'b1;
                sel_lvl = PW'(l);
                sel_src = lvl_idx[l];
            end
        end
    end

    // Grant the smaller of the pending quota and the free budget.
    always_comb begin
        pick_x = WW'(slot_amt[sel_src]);
        gamt   = QW'((pick_x < free_x) ? pick_x : free_x);
        give   = any_vld && (free_w != '0) && !cfg_take;
    end

    assign add_en  = cfg_take || give;
    assign add_amt = cfg_take ? cfg_credit : gamt;

    qr_budget #(.CAP(CAP), .QW(QW)) u_bud (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (add_en),
        .add_amt (add_amt),
        .sub_en  (cons_valid),
        .sub_amt (cons_amt),
        .free    (free_w)
    );

    // Register the outgoing grant message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            gnt_src   <= '0;
            gnt_amt   <= '0;
            gnt_pre   <= 1'b0;
        end else begin
            gnt_valid <= add_en;
            gnt_src   <= cfg_take ? cfg_src : sel_src;
            gnt_amt   <= add_amt;
            gnt_pre   <= cfg_take;
        end
    end

    assign gnt_lvl = LVW'(TOP_LVL);

endmodule

// File: rtl/qr_checker.sv
// Temporal checks on the regulator's grant channel against its budget and
// configuration inputs. Attached to every regulator instance by bind.
module qr_checker #(
    parameter int SW = 2,
    parameter int QW = 8,
    parameter int BW = 6,
    localparam int WW = ((QW > BW) ? QW : BW) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gnt_valid,
    input logic [SW-1:0] gnt_src,
    input logic [QW-1:0] gnt_amt,
    input logic          gnt_pre,
    input logic          cfg_we,
    input logic [SW-1:0] cfg_src,
    input logic [QW-1:0] cfg_credit,
    input logic [BW-1:0] free
);

    logic [WW-1:0] cred_x;
    logic [WW-1:0] free_x;
    logic [WW-1:0] amt_x;
    logic          fits;

    assign cred_x = WW'(cfg_credit);
    assign free_x = WW'(free);
    assign amt_x  = WW'(gnt_amt);
    assign fits   = cfg_we && (cfg_credit != '0) && (cred_x <= free_x);

    // R4: a grant never carries zero flits.
    p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (gnt_amt != '0));

    // R5: a request grant stays within the budget free the cycle before.
    p_within_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_pre) |-> (amt_x <= $past(free_x)));

    // R5: with nothing free, the next cycle carries no grant.
    p_dry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (free == '0) |=> !gnt_valid);

    // R10: an accepted preload appears as a flagged grant one edge later.
    p_preload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fits |=> (gnt_valid && gnt_pre && gnt_src == $past(cfg_src)
                  && gnt_amt == $past(cfg_credit)));

    // R11: a refused preload never shows up as a flagged grant.
    p_refused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fits |=> !gnt_pre);

endmodule

bind hm_quota_regulator qr_checker #(.SW(SW), .QW(QW), .BW(BW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gnt_valid  (gnt_valid),
    .gnt_src    (gnt_src),
    .gnt_amt    (gnt_amt),
    .gnt_pre    (gnt_pre),
    .cfg_we     (cfg_we),
    .cfg_src    (cfg_src),
    .cfg_credit (cfg_credit),
    .free       (free_w)
);

// File: tb/sim_hm_quota_regulator.sv
// Scoreboard bench: driver tasks queue the grants the requirements predict,
// a monitor pops and compares every grant the regulator sends.
module sim_hm_quota_regulator;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 2;
    localparam int PW = 1;
    localparam int QW = 8;
    localparam int LVW = 2;
    localparam int TOP = 3;

    typedef struct {
        int    src;
        int    amt;
        bit    pre;
        string tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [SW-1:0]  req_src = '0;
    logic [LVW-1:0] req_lvl = '0;
    logic [PW-1:0]  req_pri = '0;
    logic [QW-1:0]  req_amt = '0;
    logic [QW-1:0]  req_qsize = '0;
    logic           cfg_we = 1'b0;
    logic [SW-1:0]  cfg_src = '0;
    logic [QW-1:0]  cfg_credit = '0;
    logic           cons_valid = 1'b0;
    logic [QW-1:0]  cons_amt = '0;
    logic           gnt_valid;
    logic [SW-1:0]  gnt_src;
    logic [QW-1:0]  gnt_amt;
    logic           gnt_pre;
    logic [LVW-1:0] gnt_lvl;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    hm_quota_regulator u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_src    (req_src),
        .req_lvl    (req_lvl),
        .req_pri    (req_pri),
        .req_amt    (req_amt),
        .req_qsize  (req_qsize),
        .cfg_we     (cfg_we),
        .cfg_src    (cfg_src),
        .cfg_credit (cfg_credit),
        .cons_valid (cons_valid),
        .cons_amt   (cons_amt),
        .gnt_valid  (gnt_valid),
        .gnt_src    (gnt_src),
        .gnt_amt    (gnt_amt),
        .gnt_pre    (gnt_pre),
        .gnt_lvl    (gnt_lvl)
    );

    task automatic expect_gnt(input int src, input int amt, input bit pre, input string tag);
        exp_t e;
        e.src = src; e.amt = amt; e.pre = pre; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic send_req(input int src, input int amt, input int qs,
                            input int pri, input int lvl);
        req_valid = 1'b1; req_src = SW'(src); req_amt = QW'(amt);
        req_qsize = QW'(qs); req_pri = PW'(pri); req_lvl = LVW'(lvl);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic preload(input int src, input int cred);
        cfg_we = 1'b1; cfg_src = SW'(src); cfg_credit = QW'(cred);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic consume(input int amt);
        cons_valid = 1'b1; cons_amt = QW'(amt);
        @(negedge clk);
        cons_valid = 1'b0;
    endtask

    // Let the design settle, then require that every predicted grant arrived.
    task automatic drain(input string tag);
        repeat (8) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s: %0d grants missing, expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Monitor: compare each grant with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && gnt_valid && !done) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected grant: got src=%0d amt=%0d pre=%0d, expected none",
                         gnt_src, gnt_amt, gnt_pre);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (int'(gnt_src) != e.src || int'(gnt_amt) != e.amt ||
                    gnt_pre != e.pre || int'(gnt_lvl) != TOP) begin
                    n_bad++;
                    $display("FAIL %s: got src=%0d amt=%0d pre=%0d lvl=%0d, expected src=%0d amt=%0d pre=%0d lvl=%0d",
                             e.tag, gnt_src, gnt_amt, gnt_pre, gnt_lvl,
                             e.src, e.amt, e.pre, TOP);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: idle grant channel after reset; top level on the grant.
        n_chk++;
        if (gnt_valid !== 1'b0 || int'(gnt_lvl) != TOP) begin
            n_bad++;
            $display("FAIL R1: got valid=%0b lvl=%0d, expected valid=0 lvl=%0d",
                     gnt_valid, gnt_lvl, TOP);
        end
        // R1, R10: full budget free after reset, a CAP preload is accepted.
        expect_gnt(0, 32, 1'b1, "R1 full budget preload");
        preload(0, 32);
        drain("R1");
        consume(32);

        // R2: an off-level request is ignored, a top-level one is granted.
        send_req(1, 5, 9, 0, 1);
        drain("R2 off-level ignored");
        expect_gnt(1, 5, 1'b0, "R2/R4 top-level grant");
        send_req(1, 5, 9, 0, 3);
        drain("R2");
        consume(5);

        // R3: ask clipped to queue size; zero ask ignored.
        expect_gnt(2, 4, 1'b0, "R3 clipped ask");
        send_req(2, 10, 4, 0, 3);
        send_req(2, 0, 5, 0, 3);
        drain("R3");
        consume(4);

        // R5, R6: partial grants, remainder held until capacity returns.
        expect_gnt(3, 30, 1'b1, "R10 preload 30");
        preload(3, 30);
        expect_gnt(0, 2, 1'b0, "R5 partial grant");
        send_req(0, 6, 6, 0, 3);
        drain("R5 no grant while dry");
        expect_gnt(0, 3, 1'b0, "R6 remainder part");
        consume(3);
        drain("R6 first return");
        expect_gnt(0, 1, 1'b0, "R6 remainder rest");
        consume(10);
        drain("R6");
        consume(23);

        // R12: over-consumption saturates; R11: refused preloads.
        consume(50);
        expect_gnt(1, 32, 1'b1, "R12 no wrap after over-consume");
        preload(1, 32);
        preload(1, 1);
        preload(2, 0);
        drain("R11 refused preloads");
        consume(32);
        expect_gnt(2, 32, 1'b1, "R11 refused preload reserved nothing");
        preload(2, 32);
        drain("R11");
        consume(32);

        // R7: higher priority first.
        expect_gnt(0, 32, 1'b1, "R7 fill");
        preload(0, 32);
        send_req(1, 2, 2, 0, 3);
        send_req(2, 2, 2, 1, 3);
        expect_gnt(2, 2, 1'b0, "R7 high priority first");
        expect_gnt(1, 2, 1'b0, "R7 low priority second");
        consume(4);
        drain("R7");
        consume(32);

        // R8: round-robin at level 0; last winner there was source 1.
        expect_gnt(3, 32, 1'b1, "R8 fill");
        preload(3, 32);
        send_req(0, 1, 1, 0, 3);
        send_req(1, 1, 1, 0, 3);
        send_req(2, 1, 1, 0, 3);
        expect_gnt(2, 1, 1'b0, "R8 rotation 1st");
        expect_gnt(0, 1, 1'b0, "R8 rotation 2nd");
        expect_gnt(1, 1, 1'b0, "R8 rotation 3rd");
        consume(3);
        drain("R8");
        consume(32);

        // R9: a second request replaces the pending one.
        expect_gnt(0, 32, 1'b1, "R9 fill");
        preload(0, 32);
        send_req(1, 5, 5, 0, 3);
        send_req(1, 3, 3, 1, 3);
        expect_gnt(1, 3, 1'b0, "R9 replaced quota");
        consume(8);
        drain("R9");
        consume(27);

        // R10: preload takes the grant slot; the request grant follows.
        send_req(2, 4, 4, 0, 3);
        expect_gnt(3, 5, 1'b1, "R10 preload wins slot");
        expect_gnt(2, 4, 1'b0, "R10 deferred request");
        preload(3, 5);
        drain("R10");
        consume(9);

        done = 1'b1;
        report();
    end

endmodule